// File: doc/BRIEF.md
# Asynchronous Serial Transmit Channel

This block is one transmit lane of a UART. A host pushes characters into a 16-entry queue. A serializer takes them out one at a time and sends each on the serial line as a start bit, 5 to 8 data bits (least significant first), an optional parity bit and one or two stop bits. Bit timing comes from a one-cycle baud enable pulse, `baud_tick`, which the surrounding logic raises once per bit time. Every serial bit lasts exactly one tick period.

Two status outputs report the channel state. `tx_rdy` tells the host that the queue can take another character. `tx_emt` says the line has drained, meaning the last stop bit has gone out and nothing is waiting. A level enable gates the channel. A 5-bit command port accepts three actions: a line break that holds the output low, an end to that break, and a transmitter reset. Every other command code is ignored.

Top module: `uart_tx_chan`

## Requirements
- R1: After `rst_n` is released with `tx_en` low, `txd` is 1, `tx_rdy` is 0 and `tx_emt` is 0.
- R2: Each character is sent as follows, with every bit lasting one `baud_tick` period: a 0 start bit; then the data bits, least significant first, numbering 5 + `cfg_len` (`cfg_len` 0 means 5 bits, 3 means 8 bits); then, when `cfg_par_en` is 1, a parity bit that makes the count of ones over data and parity even (`cfg_par_odd`=0) or odd (`cfg_par_odd`=1); then one stop bit at 1, or two when `cfg_stop2` is 1.
- R3: The queue holds 16 characters. `tx_rdy` is 1 exactly when `tx_en` is 1 and at least one slot is free. A write made while the queue is full is dropped.
- R4: While `tx_en` is 0, `tx_rdy` is 0 and writes are dropped, so those characters are never sent. `tx_rdy` rises as soon as `tx_en` rises.
- R5: `tx_emt` goes to 1 in the cycle after the final stop bit ends, provided the queue is empty at that point. An accepted write clears it in the next cycle.
- R6: `tx_emt` is 0 in every cycle that follows a cycle in which `tx_en` was 0.
- R7: Command code 00110 requests a break. Any character already being shifted out finishes first. After that, `txd` stays 0 from the next bit boundary on, and queued characters stay queued.
- R8: Command code 00111 ends a break. `txd` then returns to 1 and stays at 1 for at least one full bit time before the next start bit.
- R9: Command code 00011 resets the transmitter. It empties the queue, abandons the character in progress, cancels a pending or active break and clears `tx_emt`. From the next cycle, `txd` is 1. A write in the same cycle is dropped.
- R10: Command code 00000, and every code other than 00011, 00110 and 00111, has no effect on the line, the queue or the status outputs.
- R11: Queued characters are sent in the order they were written, with no gap between frames when the queue is not empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| baud_tick | input | 1 | One-cycle pulse marking each bit boundary |
| tx_en | input | 1 | Transmitter enable level |
| wr_valid | input | 1 | Host write strobe for a character |
| wr_data | input | 8 | Character written by the host |
| cmd_valid | input | 1 | Command strobe |
| cmd_code | input | 5 | Command code |
| cfg_len | input | 2 | Data length: 5 + value bits |
| cfg_par_en | input | 1 | Add a parity bit |
| cfg_par_odd | input | 1 | Parity sense: 1 odd, 0 even |
| cfg_stop2 | input | 1 | Two stop bits when 1 |
| txd | output | 1 | Serial output, idle high |
| tx_rdy | output | 1 | Queue can accept a character |
| tx_emt | output | 1 | Line drained and queue empty |

## Verification
The hardest state to reach is a completely full queue, because the serializer pulls a character at the next bit boundary after any write. The bench first starts a break, which freezes the drain. It then writes sixteen characters and a seventeenth that must be dropped, and watches `tx_rdy` fall on the sixteenth write. When the break ends, it measures the marking gap and checks that exactly the sixteen frames come out, in order. A second hard case is a break requested halfway through a character: the bench issues the command during the data bits and checks that the frame still completes intact before the line goes low.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_START,
        S_DATA,
        S_PAR,
        S_STOP,
        S_BREAK,
        S_MARK
    } ser_state_e;

    localparam logic [4:0] CMD_NOP     = 5'b00000;
    localparam logic [4:0] CMD_RST_TX  = 5'b00011;
    localparam logic [4:0] CMD_BRK_ON  = 5'b00110;
    localparam logic [4:0] CMD_BRK_OFF = 5'b00111;

    typedef struct packed {
        logic [1:0] len;
        logic       par_en;
        logic       par_odd;
        logic       stop2;
    } frame_cfg_t;

endpackage

// File: rtl/uart_tx_cmd_decode.sv
module uart_tx_cmd_decode
    import uart_tx_pkg::*;
(
    input  logic       cmd_valid_i,
    input  logic [4:0] cmd_code_i,
    output logic       rst_tx_o,
    output logic       brk_on_o,
    output logic       brk_off_o
);

    always_comb begin
        rst_tx_o  = 1'b0;
        brk_on_o  = 1'b0;
        brk_off_o = 1'b0;
        if (cmd_valid_i) begin
            case (cmd_code_i)
                CMD_RST_TX:  rst_tx_o  = 1'b1;
                CMD_BRK_ON:  brk_on_o  = 1'b1;
                CMD_BRK_OFF: brk_off_o = 1'b1;
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/uart_tx_fifo.sv
module uart_tx_fifo #(
    parameter int DEPTH = 16,
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush_i,
    input  logic             push_i,
    input  logic [WIDTH-1:0] data_i,
    input  logic             pop_i,
    output logic [WIDTH-1:0] data_o,
    output logic             empty_o,
    output logic             full_o
);

    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DEPTH);

    typedef struct packed {
        logic [DEPTH-1:0][WIDTH-1:0] mem;
        logic [PTR_W-1:0]            wr_ptr;
        logic [PTR_W-1:0]            rd_ptr;
        logic [CNT_W-1:0]            count;
    } fifo_regs_t;

    fifo_regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (push_i) begin
            r_d.mem[r_q.wr_ptr] = data_i;
            r_d.wr_ptr = (r_q.wr_ptr == PTR_LAST) ? '0 : r_q.wr_ptr + 1'b1;
        end
        if (pop_i) begin
            r_d.rd_ptr = (r_q.rd_ptr == PTR_LAST) ? '0 : r_q.rd_ptr + 1'b1;
        end
        case ({push_i, pop_i})
            2'b10:   r_d.count = r_q.count + 1'b1;
            2'b01:   r_d.count = r_q.count - 1'b1;
            default: r_d.count = r_q.count;
        endcase
        if (flush_i) begin
            r_d.wr_ptr = '0;
            r_d.rd_ptr = '0;
            r_d.count  = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign data_o  = r_q.mem[r_q.rd_ptr];
    assign empty_o = (r_q.count == '0);
    assign full_o  = (r_q.count == CNT_FULL);

    p_count_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.count <= CNT_FULL)
        else $error("queue count exceeds depth");

    p_pop_nonempty_r11: assert property (@(posedge clk) disable iff (!rst_n)
        pop_i |-> (r_q.count != '0))
        else $error("pop from empty queue");

    p_no_push_full_r3: assert property (@(posedge clk) disable iff (!rst_n)
        push_i |-> (r_q.count != CNT_FULL))
        else $error("push into full queue");

endmodule

// File: rtl/uart_tx_serializer.sv
module uart_tx_serializer
    import uart_tx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              flush_i,
    input  logic              brk_on_i,
    input  logic              brk_off_i,
    input  logic              load_ok_i,
    input  logic [DATA_W-1:0] load_data_i,
    input  frame_cfg_t        cfg_i,
    output logic              pop_o,
    output logic              done_o,
    output logic              txd_o
);

    localparam int CNT_W    = $clog2(DATA_W);
    localparam int MIN_BITS = DATA_W - 3;

    typedef struct packed {
        ser_state_e        state;
        logic [DATA_W-1:0] shreg;
        logic [CNT_W-1:0]  bitcnt;
        logic              par;
        logic              stop_more;
        logic              brk_pend;
        logic              mark_half;
        logic              txd;
    } ser_regs_t;

    localparam ser_regs_t SER_RST = '{
        state:     S_IDLE,
        shreg:     '0,
        bitcnt:    '0,
        par:       1'b0,
        stop_more: 1'b0,
        brk_pend:  1'b0,
        mark_half: 1'b0,
        txd:       1'b1
    };

    ser_regs_t r_d, r_q;
    logic [CNT_W-1:0] last_idx;
    logic             go;

    assign last_idx = CNT_W'(MIN_BITS - 1) + CNT_W'(cfg_i.len);

    always_comb begin
        r_d    = r_q;
        pop_o  = 1'b0;
        done_o = 1'b0;
        go     = 1'b0;

        if (brk_on_i && (r_q.state != S_BREAK)) r_d.brk_pend = 1'b1;
        if (brk_off_i)                          r_d.brk_pend = 1'b0;

        if (brk_off_i && (r_q.state == S_BREAK)) begin
            r_d.state     = S_MARK;
            r_d.mark_half = 1'b0;
            r_d.txd       = 1'b1;
        end else if (tick_i) begin
            case (r_q.state)
                S_IDLE: go = 1'b1;
                S_START: begin
                    r_d.state  = S_DATA;
                    r_d.bitcnt = '0;
                    r_d.txd    = r_q.shreg[0];
                    r_d.par    = r_q.par ^ r_q.shreg[0];
                    r_d.shreg  = r_q.shreg >> 1;
                end
                S_DATA: begin
                    if (r_q.bitcnt == last_idx) begin
                        if (cfg_i.par_en) begin
                            r_d.state = S_PAR;
                            r_d.txd   = r_q.par;
                        end else begin
                            r_d.state     = S_STOP;
                            r_d.txd       = 1'b1;
                            r_d.stop_more = cfg_i.stop2;
                        end
                    end else begin
                        r_d.bitcnt = r_q.bitcnt + 1'b1;
                        r_d.txd    = r_q.shreg[0];
                        r_d.par    = r_q.par ^ r_q.shreg[0];
                        r_d.shreg  = r_q.shreg >> 1;
                    end
                end
                S_PAR: begin
                    r_d.state     = S_STOP;
                    r_d.txd       = 1'b1;
                    r_d.stop_more = cfg_i.stop2;
                end
                S_STOP: begin
                    if (r_q.stop_more) begin
                        r_d.stop_more = 1'b0;
                    end else begin
                        done_o = 1'b1;
                        go     = 1'b1;
                    end
                end
                S_MARK: begin
                    if (!r_q.mark_half) r_d.mark_half = 1'b1;
                    else                go = 1'b1;
                end
                default: ;
            endcase
        end

        if (go) begin
            if (r_d.brk_pend) begin
                r_d.state    = S_BREAK;
                r_d.brk_pend = 1'b0;
                r_d.txd      = 1'b0;
            end else if (load_ok_i) begin
                pop_o      = 1'b1;
                r_d.state  = S_START;
                r_d.shreg  = load_data_i;
                r_d.par    = cfg_i.par_odd;
                r_d.txd    = 1'b0;
            end else begin
                r_d.state = S_IDLE;
                r_d.txd   = 1'b1;
            end
        end

        if (flush_i) begin
            r_d   = SER_RST;
            pop_o = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= SER_RST;
        else        r_q <= r_d;
    end

    assign txd_o = r_q.txd;

    p_break_no_pop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == S_BREAK) |-> !pop_o)
        else $error("queue drained during break");

    p_break_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == S_BREAK && $past(r_q.state) == S_BREAK) |-> !txd_o)
        else $error("line not held low in break");

    p_mark_high_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == S_MARK) |-> txd_o)
        else $error("line not marking after break");

    p_mark_to_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == S_START && $past(r_q.state) == S_MARK) |-> $past(r_q.mark_half))
        else $error("start bit too soon after break");

endmodule

// File: rtl/uart_tx_status.sv
module uart_tx_status (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    input  logic push_i,
    input  logic flush_i,
    input  logic done_i,
    input  logic fifo_empty_i,
    input  logic fifo_full_i,
    output logic tx_emt_o,
    output logic tx_rdy_o
);

    typedef struct packed {
        logic emt;
    } stat_regs_t;

    stat_regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (done_i && fifo_empty_i) r_d.emt = 1'b1;
        if (push_i)                 r_d.emt = 1'b0;
        if (!en_i || flush_i)       r_d.emt = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign tx_emt_o = r_q.emt;
    assign tx_rdy_o = en_i & ~fifo_full_i;

    p_emt_off_disabled_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> !tx_emt_o)
        else $error("empty flag while disabled");

    p_emt_clear_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
        push_i |=> !tx_emt_o)
        else $error("empty flag after load");

endmodule

// File: rtl/uart_tx_chan.sv
module uart_tx_chan
    import uart_tx_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int FIFO_DEPTH = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              baud_tick,
    input  logic              tx_en,
    input  logic              wr_valid,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              cmd_valid,
    input  logic [4:0]        cmd_code,
    input  logic [1:0]        cfg_len,
    input  logic              cfg_par_en,
    input  logic              cfg_par_odd,
    input  logic              cfg_stop2,
    output logic              txd,
    output logic              tx_rdy,
    output logic              tx_emt
);

    logic              rst_tx, brk_on, brk_off;
    logic              fifo_empty, fifo_full, accept, pop, done;
    logic [DATA_W-1:0] head;
    frame_cfg_t        cfg;

    assign cfg    = '{len: cfg_len, par_en: cfg_par_en, par_odd: cfg_par_odd, stop2: cfg_stop2};
    assign accept = wr_valid & tx_en & ~fifo_full & ~rst_tx;

    uart_tx_cmd_decode u_dec (
        .cmd_valid_i (cmd_valid),
        .cmd_code_i  (cmd_code),
        .rst_tx_o    (rst_tx),
        .brk_on_o    (brk_on),
        .brk_off_o   (brk_off)
    );

    uart_tx_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(DATA_W)) u_fifo (
        .clk     (clk),
        .rst_n   (rst_n),
        .flush_i (rst_tx),
        .push_i  (accept),
        .data_i  (wr_data),
        .pop_i   (pop),
        .data_o  (head),
        .empty_o (fifo_empty),
        .full_o  (fifo_full)
    );

    uart_tx_serializer #(.DATA_W(DATA_W)) u_ser (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick_i      (baud_tick),
        .flush_i     (rst_tx),
        .brk_on_i    (brk_on),
        .brk_off_i   (brk_off),
        .load_ok_i   (tx_en & ~fifo_empty),
        .load_data_i (head),
        .cfg_i       (cfg),
        .pop_o       (pop),
        .done_o      (done),
        .txd_o       (txd)
    );

    uart_tx_status u_stat (
        .clk          (clk),
        .rst_n        (rst_n),
        .en_i         (tx_en),
        .push_i       (accept),
        .flush_i      (rst_tx),
        .done_i       (done),
        .fifo_empty_i (fifo_empty),
        .fifo_full_i  (fifo_full),
        .tx_emt_o     (tx_emt),
        .tx_rdy_o     (tx_rdy)
    );

    p_reset_cmd_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_code == CMD_RST_TX) |=> (txd && !tx_emt))
        else $error("transmitter reset did not idle the line");

    p_disabled_no_rdy_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_en && wr_valid) |=> !tx_emt)
        else $error("disabled write changed status");

endmodule

// File: tb/uart_tx_chan_test.sv
module uart_tx_chan_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       baud_tick = 1'b0;
    logic       tx_en = 1'b0;
    logic       wr_valid = 1'b0;
    logic [7:0] wr_data = '0;
    logic       cmd_valid = 1'b0;
    logic [4:0] cmd_code = '0;
    logic [1:0] cfg_len = 2'd3;
    logic       cfg_par_en = 1'b0;
    logic       cfg_par_odd = 1'b0;
    logic       cfg_stop2 = 1'b0;
    logic       txd, tx_rdy, tx_emt;

    int  n_checks = 0;
    int  n_fail = 0;
    bit  finished = 1'b0;
    int  tcnt = 0;

    always #5 clk = ~clk;

    initial forever begin
        @(negedge clk);
        baud_tick = (tcnt == 7);
        tcnt = (tcnt == 7) ? 0 : tcnt + 1;
    end

    uart_tx_chan uut (
        .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .tx_en(tx_en),
        .wr_valid(wr_valid), .wr_data(wr_data), .cmd_valid(cmd_valid),
        .cmd_code(cmd_code), .cfg_len(cfg_len), .cfg_par_en(cfg_par_en),
        .cfg_par_odd(cfg_par_odd), .cfg_stop2(cfg_stop2),
        .txd(txd), .tx_rdy(tx_rdy), .tx_emt(tx_emt)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic write_byte(input logic [7:0] d);
        @(negedge clk);
        wr_valid = 1'b1;
        wr_data  = d;
        @(negedge clk);
        wr_valid = 1'b0;
    endtask

    task automatic send_cmd(input logic [4:0] c);
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_code  = c;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic set_cfg(input logic [1:0] l, input bit pe, input bit po, input bit s2);
        @(negedge clk);
        cfg_len = l; cfg_par_en = pe; cfg_par_odd = po; cfg_stop2 = s2;
    endtask

    task automatic check_frame(input logic [7:0] d, input string req);
        int         w = 0;
        int         nb = 5 + int'(cfg_len);
        logic [7:0] mask = 8'((1 << nb) - 1);
        logic [7:0] got = '0;
        logic       pexp;
        @(negedge clk);
        while (txd !== 1'b0 && w < 3000) begin
            @(negedge clk);
            w++;
        end
        if (w >= 3000) begin
            check(1'b0, req, "start bit timeout", int'(txd), 0);
            return;
        end
        repeat (4) @(negedge clk);
        check(txd === 1'b0, req, "start bit", int'(txd), 0);
        for (int i = 0; i < nb; i++) begin
            repeat (8) @(negedge clk);
            got[i] = txd;
        end
        check(got == (d & mask), req, "data bits", int'(got), int'(d & mask));
        if (cfg_par_en) begin
            pexp = (^(d & mask)) ^ cfg_par_odd;
            repeat (8) @(negedge clk);
            check(txd === pexp, req, "parity bit", int'(txd), int'(pexp));
        end
        repeat (8) @(negedge clk);
        check(txd === 1'b1, req, "stop bit", int'(txd), 1);
        if (cfg_stop2) begin
            repeat (8) @(negedge clk);
            check(txd === 1'b1, req, "second stop bit", int'(txd), 1);
        end
    endtask

    task automatic t_reset_state;
        check(txd === 1'b1, "R1", "txd after reset", int'(txd), 1);
        check(tx_rdy === 1'b0, "R1", "tx_rdy after reset", int'(tx_rdy), 0);
        check(tx_emt === 1'b0, "R1", "tx_emt after reset", int'(tx_emt), 0);
    endtask

    task automatic t_disabled_write;
        int lows = 0;
        write_byte(8'h11);
        check(tx_rdy === 1'b0, "R4", "tx_rdy while disabled", int'(tx_rdy), 0);
        @(negedge clk);
        tx_en = 1'b1;
        #1;
        check(tx_rdy === 1'b1, "R4", "tx_rdy on enable", int'(tx_rdy), 1);
        repeat (200) begin
            @(negedge clk);
            if (txd !== 1'b1) lows++;
        end
        check(lows == 0, "R4", "line activity from dropped write", lows, 0);
        check(tx_emt === 1'b0, "R4", "tx_emt with nothing sent", int'(tx_emt), 0);
    endtask

    task automatic t_basic_frame;
        set_cfg(2'd3, 1'b0, 1'b0, 1'b0);
        write_byte(8'hA5);
        check_frame(8'hA5, "R2");
        repeat (8) @(negedge clk);
        check(tx_emt === 1'b1, "R5", "tx_emt after last stop", int'(tx_emt), 1);
        write_byte(8'h0F);
        check(tx_emt === 1'b0, "R5", "tx_emt after load", int'(tx_emt), 0);
        check_frame(8'h0F, "R2");
        repeat (8) @(negedge clk);
        check(tx_emt === 1'b1, "R5", "tx_emt after second frame", int'(tx_emt), 1);
    endtask

    task automatic t_disable_clears_emt;
        @(negedge clk);
        tx_en = 1'b0;
        @(negedge clk);
        check(tx_emt === 1'b0, "R6", "tx_emt while disabled", int'(tx_emt), 0);
        check(tx_rdy === 1'b0, "R4", "tx_rdy while disabled", int'(tx_rdy), 0);
        tx_en = 1'b1;
        repeat (2) @(negedge clk);
        check(tx_emt === 1'b0, "R6", "tx_emt stays low after re-enable", int'(tx_emt), 0);
    endtask

    task automatic t_formats;
        set_cfg(2'd2, 1'b1, 1'b0, 1'b1);
        write_byte(8'h4B);
        check_frame(8'h4B, "R2");
        set_cfg(2'd0, 1'b1, 1'b1, 1'b0);
        repeat (20) @(negedge clk);
        write_byte(8'h13);
        check_frame(8'h13, "R2");
        set_cfg(2'd1, 1'b1, 1'b1, 1'b0);
        repeat (20) @(negedge clk);
        write_byte(8'h2E);
        check_frame(8'h2E, "R2");
        set_cfg(2'd3, 1'b0, 1'b0, 1'b0);
        repeat (20) @(negedge clk);
    endtask

    task automatic t_break_after_char;
        write_byte(8'h3C);
        fork
            check_frame(8'h3C, "R7");
            begin
                @(negedge clk);
                while (txd !== 1'b0) @(negedge clk);
                repeat (12) @(negedge clk);
                send_cmd(5'b00110);
            end
        join
        repeat (12) @(negedge clk);
        check(txd === 1'b0, "R7", "line low after char then break", int'(txd), 0);
        repeat (24) @(negedge clk);
        check(txd === 1'b0, "R7", "line still low in break", int'(txd), 0);
        check(tx_emt === 1'b1, "R5", "tx_emt with empty queue in break", int'(tx_emt), 1);
        send_cmd(5'b00111);
        repeat (30) @(negedge clk);
        check(txd === 1'b1, "R8", "line marking after break end", int'(txd), 1);
    endtask

    task automatic t_full_queue_order;
        int gap = 0;
        send_cmd(5'b00110);
        repeat (20) @(negedge clk);
        check(txd === 1'b0, "R7", "break from idle", int'(txd), 0);
        for (int i = 0; i < 16; i++) begin
            write_byte(8'(i * 7 + 1));
            if (i == 14) check(tx_rdy === 1'b1, "R3", "tx_rdy with one slot free", int'(tx_rdy), 1);
        end
        check(tx_rdy === 1'b0, "R3", "tx_rdy with queue full", int'(tx_rdy), 0);
        write_byte(8'hEE);
        repeat (30) @(negedge clk);
        check(txd === 1'b0, "R7", "queue held during break", int'(txd), 0);
        check(tx_rdy === 1'b0, "R7", "queue not drained in break", int'(tx_rdy), 0);
        send_cmd(5'b00111);
        while (txd !== 1'b0 && gap < 100) begin
            @(negedge clk);
            gap++;
        end
        check(gap >= 8 && gap < 100, "R8", "marking cycles before start", gap, 8);
        for (int i = 0; i < 16; i++) check_frame(8'(i * 7 + 1), "R11");
        begin
            int lows = 0;
            repeat (200) begin
                @(negedge clk);
                if (txd !== 1'b1) lows++;
            end
            check(lows == 0, "R3", "dropped write not sent", lows, 0);
        end
        check(tx_emt === 1'b1, "R5", "tx_emt after queue drained", int'(tx_emt), 1);
    endtask

    task automatic t_ignored_cmds;
        set_cfg(2'd3, 1'b1, 1'b0, 1'b0);
        write_byte(8'h5A);
        fork
            check_frame(8'h5A, "R10");
            begin
                repeat (30) @(negedge clk);
                send_cmd(5'b00000);
                send_cmd(5'b00001);
                send_cmd(5'b01000);
                send_cmd(5'b11111);
            end
        join
        send_cmd(5'b00110);
        repeat (30) @(negedge clk);
        send_cmd(5'b00010);
        send_cmd(5'b00100);
        send_cmd(5'b01111);
        send_cmd(5'b00000);
        repeat (30) @(negedge clk);
        check(txd === 1'b0, "R10", "break kept through other codes", int'(txd), 0);
        check(tx_emt === 1'b1, "R10", "tx_emt kept through other codes", int'(tx_emt), 1);
        send_cmd(5'b00111);
        repeat (30) @(negedge clk);
        set_cfg(2'd3, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic t_reset_cmd;
        int lows = 0;
        write_byte(8'h81);
        write_byte(8'h82);
        write_byte(8'h83);
        @(negedge clk);
        while (txd !== 1'b0) @(negedge clk);
        repeat (20) @(negedge clk);
        send_cmd(5'b00011);
        check(txd === 1'b1, "R9", "txd after reset command", int'(txd), 1);
        check(tx_emt === 1'b0, "R9", "tx_emt after reset command", int'(tx_emt), 0);
        check(tx_rdy === 1'b1, "R9", "tx_rdy after reset command", int'(tx_rdy), 1);
        repeat (300) begin
            @(negedge clk);
            if (txd !== 1'b1) lows++;
        end
        check(lows == 0, "R9", "queue flushed, nothing sent", lows, 0);
        send_cmd(5'b00110);
        repeat (30) @(negedge clk);
        check(txd === 1'b0, "R9", "break active before reset", int'(txd), 0);
        send_cmd(5'b00011);
        check(txd === 1'b1, "R9", "reset cancels break", int'(txd), 1);
        repeat (40) @(negedge clk);
        check(txd === 1'b1, "R9", "line stays idle after reset", int'(txd), 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_state();
        t_disabled_write();
        t_basic_frame();
        t_disable_clears_emt();
        t_formats();
        t_break_after_char();
        t_full_queue_order();
        t_ignored_cmds();
        t_reset_cmd();
        if (!finished) begin
            finished = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

endmodule